// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block sits between a host register file and the card-side request path of a memory-card host controller. Software loads a 32-bit argument and then writes an 11-bit command word. When that word asks for the command to start and does not ask for deferred (pending) operation, the block sends the 6-bit command index and the argument to the card side as a one-cycle request. It then waits for the card's reply.

The card side answers with a stream of response bytes, one per cycle, and ends the reply with a done strobe and an error flag. The block counts the bytes and checks the count against the response type the command word asked for. It packs the bytes big-endian into four 32-bit response words and posts one of three sticky status flags: response received, command sent without a response, or timeout. A built-in cycle limit turns a reply that never arrives into a timeout. The status flags are cleared by writing ones to them.

Top module: `cmdResponseUnit`

## Requirements
- R1: After reset the request strobe, command word, argument, all four response words and all status bits are zero.
- R2: A command write while idle that has bit 10 (enable) set and bit 9 (pending) clear raises `reqValid` for exactly one cycle, starting the cycle after the write. During that cycle `reqIndex` shows command bits 5:0 and `reqArg` shows the stored argument. Status bit 11 (active) is high from that same cycle until the command ends. Bit 8 has no effect on issue.
- R3: The stored copy of bit 10 stays 1 while a command is in flight and drops to 0 in the cycle the command ends. A command write with bit 9 set issues nothing and stores bit 10 as 0. Command and argument writes made while a command is in flight are ignored.
- R4: Response bytes are packed in arrival order, and the first byte goes to bits 31:24 of word 0. A 4-byte reply fills word 0 and forces words 1 to 3 to zero.
- R5: A 16-byte reply fills words 0 to 3, with bytes 0-3 in word 0 and bytes 12-15 in word 3, and bit 0 of word 3 is forced to 0. A 16-byte reply is stored this way even when command bit 7 (long) is clear.
- R6: A completion without error sets status bit 6 when command bit 6 (response expected) is set. It sets status bit 7 when bit 6 is clear, whatever the byte count, and in that case the response words are left unchanged.
- R7: Status bit 2 (timeout) is set, and the response words are left unchanged, when any of these holds: the card raises `rspErr` with done; a response was expected and 0 bytes came; a long response was expected and 4 bytes came; a response was expected and the byte count is neither 4 nor 16.
- R8: If `rspDone` does not arrive within TIMEOUT_CYCLES cycles of issue, status bit 2 is set and the command ends. A `rspDone` that comes later is ignored.
- R9: A `statusClr` bit set to 1 clears status bit 2, 6 or 7 at the next edge. A flag being set in the same cycle wins over its clear, and bit 11 cannot be cleared this way.
- R10: Response bytes and done strobes that arrive while no command is in flight change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWrData | input | 11 | Command word: index 5:0, response 6, long 7, interrupt 8, pending 9, enable 10 |
| argWrEn | input | 1 | Argument write strobe |
| argWrData | input | 32 | Argument value |
| statusClr | input | 12 | Write-one-to-clear mask for status bits 2, 6, 7 |
| reqValid | output | 1 | One-cycle command request to the card side |
| reqIndex | output | 6 | Command index of the request |
| reqArg | output | 32 | Argument of the request |
| rspByteValid | input | 1 | Response byte strobe |
| rspByte | input | 8 | Response byte |
| rspDone | input | 1 | Reply finished |
| rspErr | input | 1 | Card reported an error (with rspDone) |
| cmdWord | output | 11 | Stored command word |
| cmdArg | output | 32 | Stored argument |
| respWord0 | output | 32 | Response word 0 |
| respWord1 | output | 32 | Response word 1 |
| respWord2 | output | 32 | Response word 2 |
| respWord3 | output | 32 | Response word 3 |
| status | output | 12 | Status: timeout 2, response end 6, sent 7, active 11 |

## Verification
The bench targets these cases:
- Long replies whose last byte is odd: a design that does not mask bit 0 would show it in word 3.
- Short commands that receive 16 bytes: a design that chooses the packing by the requested type rather than the byte count would leave words 1 to 3 wrong.
- Each of the four length and error rejections: a design that misses one would post a response-end flag and overwrite the words when it should post a timeout.
- A reply that never comes, followed by a late done: this exposes an off-by-one cycle limit and a late done that is not ignored.
- Set-versus-clear races and pending-mode writes: these expose the wrong priority and stray issue.

// File: rtl/cmdresp_pkg.sv
package cmdresp_pkg;
  localparam int IDX_W     = 6;
  localparam int CMD_W     = 11;
  localparam int BIT_RESP  = 6;
  localparam int BIT_LONG  = 7;
  localparam int BIT_PEND  = 9;
  localparam int BIT_EN    = 10;

  localparam int STAT_W     = 12;
  localparam int ST_TIMEOUT = 2;
  localparam int ST_RESPEND = 6;
  localparam int ST_SENT    = 7;
  localparam int ST_ACTIVE  = 11;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic issue;
    logic shiftByte;
    logic finish;
    logic setTimeout;
    logic setRespEnd;
    logic setSent;
    logic loadShort;
    logic loadLong;
  } ctrlStrobes_t;
endpackage

// File: rtl/cmdCtrl.sv
module cmdCtrl
  import cmdresp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int CNT_W          = 5,
  parameter int SHORT_BYTES    = 4,
  parameter int LONG_BYTES     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic [CMD_W-1:0]   cmdWrData,
  input  logic               rspByteValid,
  input  logic               rspDone,
  input  logic               rspErr,
  input  logic               respExp,
  input  logic               respLong,
  input  logic [CNT_W-1:0]   byteCnt,
  output ctrlStrobes_t       strb,
  output logic               active,
  output logic               reqValid
);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES) + 1;
  localparam logic [TMR_W-1:0] TMR_LAST  = TMR_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_BYTES);
  localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_BYTES);

  typedef enum logic {IDLE_S, WAIT_S} state_t;

  state_t           state;
  logic [TMR_W-1:0] timer;
  logic             badLen;

  // length rules for a command that expects a response
  always_comb begin
    badLen = (byteCnt == '0)
           | (respLong && (byteCnt == SHORT_CNT))
           | ((byteCnt != SHORT_CNT) && (byteCnt != LONG_CNT));
  end

  always_comb begin
    strb = '0;
    case (state)
      IDLE_S: begin
        strb.issue = cmdWrEn & cmdWrData[BIT_EN] & ~cmdWrData[BIT_PEND];
      end
      WAIT_S: begin
        if (rspDone) begin
          strb.finish = 1'b1;
          if (rspErr) begin
            strb.setTimeout = 1'b1;
          end else if (!respExp) begin
            strb.setSent = 1'b1;
          end else if (badLen) begin
            strb.setTimeout = 1'b1;
          end else begin
            strb.setRespEnd = 1'b1;
            if (byteCnt == SHORT_CNT) strb.loadShort = 1'b1;
            else                      strb.loadLong  = 1'b1;
          end
        end else begin
          strb.shiftByte = rspByteValid;
          if (timer == TMR_LAST) begin
            strb.finish     = 1'b1;
            strb.setTimeout = 1'b1;
          end
        end
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE_S;
      timer    <= '0;
      reqValid <= 1'b0;
    end else begin
      reqValid <= strb.issue;
      if (strb.issue) begin
        state <= WAIT_S;
        timer <= '0;
      end else if (strb.finish) begin
        state <= IDLE_S;
      end else if (state == WAIT_S) begin
        timer <= timer + 1'b1;
      end
    end
  end

  assign active = (state == WAIT_S);
endmodule

// File: rtl/cmdDatapath.sv
module cmdDatapath
  import cmdresp_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobes_t                      strb,
  input  logic                              active,
  input  logic                              cmdWrEn,
  input  logic [CMD_W-1:0]                  cmdWrData,
  input  logic                              argWrEn,
  input  logic [WORD_W-1:0]                 argWrData,
  input  logic [BYTE_W-1:0]                 rspByte,
  input  logic [STAT_W-1:0]                 statusClr,
  output logic [CMD_W-1:0]                  cmdWord,
  output logic [WORD_W-1:0]                 cmdArg,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  respWords,
  output logic [STAT_W-1:0]                 status,
  output logic                              respExp,
  output logic                              respLong,
  output logic [CNT_W-1:0]                  byteCnt,
  output logic [IDX_W-1:0]                  reqIndex,
  output logic [WORD_W-1:0]                 reqArg
);
  localparam int BUF_W      = WORD_W * NUM_WORDS;
  localparam int LONG_BYTES = BUF_W / BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LONG_BYTES);

  logic [CMD_W-1:0]  cmdReg;
  logic [WORD_W-1:0] argReg;
  logic [BUF_W-1:0]  shiftBuf;
  logic              toFlag, reFlag, sentFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      argReg <= '0;
    end else begin
      if (cmdWrEn && !active) begin
        cmdReg <= {strb.issue, cmdWrData[BIT_EN-1:0]};
      end else if (strb.finish) begin
        cmdReg[BIT_EN] <= 1'b0;
      end
      if (argWrEn && !active) argReg <= argWrData;
    end
  end

  // bytes enter at the bottom so the first one ends up highest
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftBuf <= '0;
      byteCnt  <= '0;
    end else if (strb.issue) begin
      shiftBuf <= '0;
      byteCnt  <= '0;
    end else if (strb.shiftByte) begin
      if (byteCnt < CNT_FULL) shiftBuf <= {shiftBuf[BUF_W-BYTE_W-1:0], rspByte};
      if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    localparam logic [WORD_W-1:0] KEEP =
      (w == NUM_WORDS - 1) ? ~(WORD_W'(1)) : {WORD_W{1'b1}};
    always_ff @(posedge clk) begin
      if (!rstN) begin
        respWords[w] <= '0;
      end else if (strb.loadShort) begin
        if (w == 0) respWords[w] <= shiftBuf[WORD_W-1:0];
        else        respWords[w] <= '0;
      end else if (strb.loadLong) begin
        respWords[w] <= shiftBuf[BUF_W-1-w*WORD_W -: WORD_W] & KEEP;
      end
    end
  end

  // clear first, then a same-cycle set wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      toFlag   <= 1'b0;
      reFlag   <= 1'b0;
      sentFlag <= 1'b0;
    end else begin
      toFlag   <= (toFlag   & ~statusClr[ST_TIMEOUT]) | strb.setTimeout;
      reFlag   <= (reFlag   & ~statusClr[ST_RESPEND]) | strb.setRespEnd;
      sentFlag <= (sentFlag & ~statusClr[ST_SENT])    | strb.setSent;
    end
  end

  always_comb begin
    status             = '0;
    status[ST_TIMEOUT] = toFlag;
    status[ST_RESPEND] = reFlag;
    status[ST_SENT]    = sentFlag;
    status[ST_ACTIVE]  = active;
  end

  assign cmdWord  = cmdReg;
  assign cmdArg   = argReg;
  assign respExp  = cmdReg[BIT_RESP];
  assign respLong = cmdReg[BIT_LONG];
  assign reqIndex = cmdReg[IDX_W-1:0];
  assign reqArg   = argReg;
endmodule

// File: rtl/cmdResponseUnit.sv
module cmdResponseUnit
  import cmdresp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic [CMD_W-1:0]   cmdWrData,
  input  logic               argWrEn,
  input  logic [31:0]        argWrData,
  input  logic [STAT_W-1:0]  statusClr,
  output logic               reqValid,
  output logic [IDX_W-1:0]   reqIndex,
  output logic [31:0]        reqArg,
  input  logic               rspByteValid,
  input  logic [7:0]         rspByte,
  input  logic               rspDone,
  input  logic               rspErr,
  output logic [CMD_W-1:0]   cmdWord,
  output logic [31:0]        cmdArg,
  output logic [31:0]        respWord0,
  output logic [31:0]        respWord1,
  output logic [31:0]        respWord2,
  output logic [31:0]        respWord3,
  output logic [STAT_W-1:0]  status
);
  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 4;
  localparam int BYTE_W      = 8;
  localparam int SHORT_BYTES = WORD_W / BYTE_W;
  localparam int LONG_BYTES  = SHORT_BYTES * NUM_WORDS;
  localparam int CNT_W       = $clog2(LONG_BYTES) + 1;

  ctrlStrobes_t                     strb;
  logic                             active;
  logic                             respExp, respLong;
  logic [CNT_W-1:0]                 byteCnt;
  logic [NUM_WORDS-1:0][WORD_W-1:0] respWords;

  cmdCtrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .CNT_W(CNT_W),
    .SHORT_BYTES(SHORT_BYTES),
    .LONG_BYTES(LONG_BYTES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .rspByteValid(rspByteValid), .rspDone(rspDone), .rspErr(rspErr),
    .respExp(respExp), .respLong(respLong), .byteCnt(byteCnt),
    .strb(strb), .active(active), .reqValid(reqValid)
  );

  cmdDatapath #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .active(active),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .argWrEn(argWrEn), .argWrData(argWrData),
    .rspByte(rspByte), .statusClr(statusClr),
    .cmdWord(cmdWord), .cmdArg(cmdArg), .respWords(respWords),
    .status(status), .respExp(respExp), .respLong(respLong),
    .byteCnt(byteCnt), .reqIndex(reqIndex), .reqArg(reqArg)
  );

  assign respWord0 = respWords[0];
  assign respWord1 = respWords[1];
  assign respWord2 = respWords[2];
  assign respWord3 = respWords[3];
endmodule

// File: rtl/cmdRespChk.sv
module cmdRespChk #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [10:0] cmdWord,
  input logic [11:0] status,
  input logic [31:0] respWord3
);
  localparam int ACT_W = $clog2(TIMEOUT_CYCLES + 2) + 1;
  logic [ACT_W-1:0] actCnt;

  always_ff @(posedge clk) begin
    if (!rstN)          actCnt <= '0;
    else if (status[11]) actCnt <= actCnt + 1'b1;
    else                actCnt <= '0;
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);
  // R2
  req_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> status[11]);
  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[11] |-> cmdWord[10]);
  // R3
  en_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[11]) |-> !cmdWord[10]);
  // R6 R7
  end_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[11]) |-> (status[2] || status[6] || status[7]));
  // R5
  long_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[6]) |-> !respWord3[0]);
  // R8
  active_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[11] |-> (actCnt < ACT_W'(TIMEOUT_CYCLES)));
endmodule

bind cmdResponseUnit cmdRespChk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .cmdWord(cmdWord),
  .status(status), .respWord3(respWord3)
);

// File: tb/tb_cmdResponseUnit.sv
module tb_cmdResponseUnit;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [10:0] cmdWrData = '0;
  logic        argWrEn = 1'b0;
  logic [31:0] argWrData = '0;
  logic [11:0] statusClr = '0;
  logic        reqValid;
  logic [5:0]  reqIndex;
  logic [31:0] reqArg;
  logic        rspByteValid = 1'b0;
  logic [7:0]  rspByte = '0;
  logic        rspDone = 1'b0;
  logic        rspErr = 1'b0;
  logic [10:0] cmdWord;
  logic [31:0] cmdArg, respWord0, respWord1, respWord2, respWord3;
  logic [11:0] status;

  cmdResponseUnit #(.TIMEOUT_CYCLES(LIMIT)) dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .argWrEn(argWrEn), .argWrData(argWrData), .statusClr(statusClr),
    .reqValid(reqValid), .reqIndex(reqIndex), .reqArg(reqArg),
    .rspByteValid(rspByteValid), .rspByte(rspByte), .rspDone(rspDone),
    .rspErr(rspErr), .cmdWord(cmdWord), .cmdArg(cmdArg),
    .respWord0(respWord0), .respWord1(respWord1), .respWord2(respWord2),
    .respWord3(respWord3), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0;
  int    bad = 0;
  string curTag = "R1";

  // behavioural reference model
  logic [10:0] mCmd;
  logic [31:0] mArg;
  logic [31:0] mW [4];
  bit          mActive, mReq, mTo, mRe, mSent;
  int          mTimer, mCnt;
  logic [7:0]  mQ [$];

  function automatic logic [31:0] packAt(int i);
    return {mQ[i], mQ[i+1], mQ[i+2], mQ[i+3]};
  endfunction

  always @(posedge clk) begin
    bit fin, sTo, sRe, sSe, wasActive, iss;
    if (!rstN) begin
      mCmd = '0; mArg = '0; mActive = 0; mReq = 0; mTo = 0; mRe = 0; mSent = 0;
      mTimer = 0; mCnt = 0; mQ.delete();
      for (int w = 0; w < 4; w++) mW[w] = '0;
    end else begin
      fin = 0; sTo = 0; sRe = 0; sSe = 0; wasActive = mActive; mReq = 0;
      if (wasActive) begin
        if (rspDone) begin
          fin = 1;
          if (rspErr) sTo = 1;
          else if (!mCmd[6]) sSe = 1;
          else if (mCnt == 0 || (mCmd[7] && mCnt == 4) || (mCnt != 4 && mCnt != 16)) sTo = 1;
          else begin
            sRe = 1;
            if (mCnt == 4) begin
              mW[0] = packAt(0); mW[1] = '0; mW[2] = '0; mW[3] = '0;
            end else begin
              for (int w = 0; w < 4; w++) mW[w] = packAt(4*w);
              mW[3][0] = 1'b0;
            end
          end
        end else begin
          if (rspByteValid) begin
            if (mQ.size() < 16) mQ.push_back(rspByte);
            if (mCnt < 31) mCnt++;
          end
          if (mTimer == LIMIT-1) begin fin = 1; sTo = 1; end
          else mTimer++;
        end
      end
      if (!wasActive && cmdWrEn) begin
        iss = cmdWrData[10] && !cmdWrData[9];
        mCmd = {iss, cmdWrData[9:0]};
        if (iss) begin
          mActive = 1; mReq = 1; mTimer = 0; mCnt = 0; mQ.delete();
        end
      end
      if (!wasActive && argWrEn) mArg = argWrData;
      if (fin) begin mActive = 0; mCmd[10] = 1'b0; end
      if (statusClr[2]) mTo = 0;
      if (statusClr[6]) mRe = 0;
      if (statusClr[7]) mSent = 0;
      if (sTo) mTo = 1;
      if (sRe) mRe = 1;
      if (sSe) mSent = 1;
    end
  end

  task automatic check(string field, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", curTag, field, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [11:0] expStat;
    expStat = {mActive, 3'b000, mSent, mRe, 3'b000, mTo, 2'b00};
    check("reqValid", 32'(reqValid), 32'(mReq));
    if (mReq) begin
      check("reqIndex", 32'(reqIndex), 32'(mCmd[5:0]));
      check("reqArg", reqArg, mArg);
    end
    check("cmdWord", 32'(cmdWord), 32'(mCmd));
    check("cmdArg", cmdArg, mArg);
    check("respWord0", respWord0, mW[0]);
    check("respWord1", respWord1, mW[1]);
    check("respWord2", respWord2, mW[2]);
    check("respWord3", respWord3, mW[3]);
    check("status", 32'(status), 32'(expStat));
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic writeCmd(logic [10:0] d);
    cmdWrEn = 1'b1; cmdWrData = d; cyc(); cmdWrEn = 1'b0;
  endtask

  task automatic writeArg(logic [31:0] d);
    argWrEn = 1'b1; argWrData = d; cyc(); argWrEn = 1'b0;
  endtask

  task automatic sendBytes(int n, logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      rspByteValid = 1'b1; rspByte = base + 8'(16*k); cyc();
    end
    rspByteValid = 1'b0;
  endtask

  task automatic finishRsp(bit err);
    rspDone = 1'b1; rspErr = err; cyc(); rspDone = 1'b0; rspErr = 1'b0;
  endtask

  task automatic clrAll();
    statusClr = 12'hFFF; cyc(); statusClr = '0;
  endtask

  task automatic runCmd(string tag, logic [31:0] arg, logic [10:0] cmd,
                        int nBytes, logic [7:0] base, bit err);
    curTag = tag;
    writeArg(arg);
    writeCmd(cmd);
    cyc(2);
    sendBytes(nBytes, base);
    finishRsp(err);
    cyc(2);
    clrAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    curTag = "R1";
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R2 R4: short response, 4 bytes
    runCmd("R2 R4", 32'hA5A5_1234, 11'h451, 4, 8'h3C, 0);
    // R5: long response, 16 bytes, odd last byte
    runCmd("R5", 32'h0000_0001, 11'h4C2, 16, 8'h0B, 0);
    // R5: short requested, 16 bytes stored as long
    runCmd("R5", 32'h0000_0002, 11'h443, 16, 8'h07, 0);
    // R6: no response expected, stray bytes, words unchanged
    runCmd("R6", 32'hDEAD_BEEF, 11'h400, 3, 8'h55, 0);
    // R7: error flag, zero length, long with 4, bad count
    runCmd("R7", 32'h1111_1111, 11'h445, 4, 8'h21, 1);
    runCmd("R7", 32'h2222_2222, 11'h446, 0, 8'h00, 0);
    runCmd("R7", 32'h3333_3333, 11'h4C7, 4, 8'h31, 0);
    runCmd("R7", 32'h4444_4444, 11'h448, 7, 8'h41, 0);
    // R8 R10: no done within the limit, late done ignored
    curTag = "R8";
    writeCmd(11'h449);
    cyc(LIMIT + 5);
    curTag = "R10";
    sendBytes(4, 8'h61);
    finishRsp(0);
    cyc(2);
    clrAll();
    // R3: pending issues nothing, interrupt bit still issues, writes in flight ignored
    curTag = "R3";
    writeCmd(11'h64A);
    cyc(3);
    writeArg(32'h7777_0000);
    writeCmd(11'h54B);
    writeCmd(11'h7FF);
    writeArg(32'h9999_9999);
    cyc(2);
    finishRsp(0);
    cyc(2);
    // R9: set wins over a same-cycle clear; active not clearable
    curTag = "R9";
    writeCmd(11'h40C);
    statusClr = 12'hFFF; cyc(); statusClr = '0;
    rspDone = 1'b1; statusClr = 12'h080; cyc(); rspDone = 1'b0; statusClr = '0;
    cyc(2);
    statusClr = 12'h004; cyc(); statusClr = '0;
    statusClr = 12'h080; cyc(); statusClr = '0;
    // R10: traffic while idle
    curTag = "R10";
    sendBytes(16, 8'h0F);
    finishRsp(1);
    cyc(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule